// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers eight interrupt request lines from peripherals and presents one interrupt signal to a small processor. Each line can be captured on a rising edge or followed as a level. A mask register filters the pending requests. A fixed-priority resolver then weighs the most urgent unmasked request against the most urgent level already being serviced. The interrupt output goes high only when the new request outranks everything in service, so handlers can nest by priority.

When the processor acknowledges, the winning level is marked in service and a vector is returned. The vector is a programmable base followed by the level number. A request that has vanished by acknowledge time yields the lowest-priority vector, and nothing is marked in service. A command write ends the most urgent in-service level. In cascade mode the controller answers an acknowledge only when the slave identifier on the cascade lines matches its own programmed ID.

Configuration goes through a four-address write-only register bus. The vector leaves on a valid strobe with no ready. There is no back-pressure: the processor must capture the vector in the single cycle that `vec_valid` is high.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `int_req`, `vec_valid` and the in-service set are all clear. The mask is all zeros, edge mode is selected, cascade matching is off and the vector base is zero.
- R2: In edge mode, a request is captured one cycle after a low-to-high change of its input. It is dropped as soon as the input is low. Once acknowledged, it returns only after a fresh rising edge.
- R3: In level mode (configuration write to address 0, bit 0 = 1), a request is pending in every cycle that its input is high.
- R4: Writing address 2 sets the mask, where bit i = 1 blocks input i. A masked request never raises `int_req`, and the mask keeps its value until it is written again.
- R5: Priority is fixed, with input 0 highest and input 7 lowest. The cycle after an acknowledge, `vec_valid` is high for exactly one cycle and `vec_data` = {base (bits 7:3 of the address-1 write), level in bits 2:0}.
- R6: `int_req` is registered. It is high in the cycle after one in which the most urgent pending unmasked request outranks the most urgent in-service level (or nothing is in service) and no acknowledge is accepted.
- R7: An accepted acknowledge with a winning request marks that level in service and consumes its edge capture. `int_req` falls the next cycle.
- R8: A write of bit 0 = 1 to address 3 is a non-specific end-of-interrupt. It removes the most urgent level from the in-service set.
- R9: An acknowledge accepted while no request qualifies returns the lowest level (7) in the vector and changes no in-service bit.
- R10: With cascade matching on (address 0, bit 1 = 1, ID in bits 6:4), an acknowledge with `cas_id` different from the programmed ID produces no vector and changes no state.
- R11: Mode, ID, base and mask can be rewritten at any time without a reset, and they take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Request lines, index 0 most urgent |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | 0 config, 1 vector base, 2 mask, 3 command |
| bus_wdata | input | 8 | Write data |
| int_ack | input | 1 | Acknowledge strobe from the processor |
| cas_id | input | 3 | Slave identifier on the cascade lines |
| int_req | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector present, one cycle |
| vec_data | output | 8 | Vector: base and level number |

## Verification
The assertions assume that every input is synchronous to `clk` and free of unknown values once reset is released. They also assume that an acknowledge counts as one event per cycle it is high. The end-of-interrupt count check ignores any cycle in which an acknowledge is accepted alongside the command. The bench changes inputs only on the falling edge and holds each acknowledge for a single cycle. Its random phase still lets acknowledge, end-of-interrupt and register writes coincide, so those overlapping cases are exercised against the reference model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W = 8;
  localparam int ID_W   = 3;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_BASE = 2'd1;
  localparam logic [1:0] ADDR_MASK = 2'd2;
  localparam logic [1:0] ADDR_CMD  = 2'd3;

  typedef struct packed {
    logic [ID_W-1:0] slave_id;
    logic            cas_en;
    logic            level_mode;
  } irqc_cfg_t;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int BASE_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wdata,
  output irqc_cfg_t          cfg,
  output logic [BASE_W-1:0]  base,
  output logic [NUM_IRQ-1:0] mask,
  output logic               eoi_cmd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      base <= '0;
      mask <= '0;
    end else if (wr) begin
      case (addr)
        ADDR_CFG: begin
          cfg.level_mode <= wdata[0];
          cfg.cas_en     <= wdata[1];
          cfg.slave_id   <= wdata[6:4];
        end
        ADDR_BASE: base <= wdata[DATA_W-1 -: BASE_W];
        ADDR_MASK: mask <= wdata[NUM_IRQ-1:0];
        default: ;
      endcase
    end
  end

  assign eoi_cmd = wr && (addr == ADDR_CMD) && wdata[0];

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == ADDR_MASK) |=> $stable(mask)); // R4
endmodule

// File: rtl/irqc_trigger.sv
module irqc_trigger #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               level_mode,
  input  logic [NUM_IRQ-1:0] consume,
  output logic [NUM_IRQ-1:0] req
);
  logic [NUM_IRQ-1:0] prev_q;
  logic [NUM_IRQ-1:0] edge_q;
  logic [NUM_IRQ-1:0] rise;

  assign rise = irq_in & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= irq_in;
      edge_q <= (edge_q | rise) & irq_in & ~consume;
    end
  end

  assign req = level_mode ? irq_in : edge_q;

  AST_EDGE_DROPS_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q & ~$past(irq_in)) == '0); // R2
endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver #(
  parameter int NUM_IRQ = 8,
  localparam int LVL_W  = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] isr,
  output logic [LVL_W-1:0]   win_idx,
  output logic [LVL_W-1:0]   svc_idx,
  output logic               svc_any,
  output logic               grant
);
  logic win_any;

  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (pend[i]) begin
        win_any = 1'b1;
        win_idx = LVL_W'(i);
      end
    end
  end

  always_comb begin
    svc_any = 1'b0;
    svc_idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (isr[i]) begin
        svc_any = 1'b1;
        svc_idx = LVL_W'(i);
      end
    end
  end

  assign grant = win_any && (!svc_any || (win_idx < svc_idx));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int VEC_W   = 8,
  localparam int LVL_W  = $clog2(NUM_IRQ),
  localparam int BASE_W = VEC_W - LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               int_ack,
  input  logic [ID_W-1:0]    cas_id,
  output logic               int_req,
  output logic               vec_valid,
  output logic [VEC_W-1:0]   vec_data
);
  localparam logic [LVL_W-1:0] LOWEST_LVL = LVL_W'(NUM_IRQ - 1);

  irqc_cfg_t          cfg;
  logic [BASE_W-1:0]  base;
  logic [NUM_IRQ-1:0] mask;
  logic               eoi_cmd;
  logic [NUM_IRQ-1:0] req, pend, isr_q, consume, retire;
  logic [LVL_W-1:0]   win_idx, svc_idx;
  logic               svc_any, grant, ack_hit, take;

  irqc_regs #(.NUM_IRQ(NUM_IRQ), .BASE_W(BASE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cfg(cfg), .base(base), .mask(mask), .eoi_cmd(eoi_cmd)
  );

  irqc_trigger #(.NUM_IRQ(NUM_IRQ)) u_trig (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(cfg.level_mode),
    .consume(consume), .req(req)
  );

  assign pend = req & ~mask;

  irqc_resolver #(.NUM_IRQ(NUM_IRQ)) u_res (
    .pend(pend), .isr(isr_q), .win_idx(win_idx), .svc_idx(svc_idx),
    .svc_any(svc_any), .grant(grant)
  );

  assign ack_hit = int_ack && (!cfg.cas_en || (cas_id == cfg.slave_id));
  assign take    = ack_hit && grant;
  assign consume = take ? (NUM_IRQ'(1) << win_idx) : '0;
  assign retire  = (eoi_cmd && svc_any) ? (NUM_IRQ'(1) << svc_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q     <= '0;
      int_req   <= 1'b0;
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else begin
      isr_q     <= (isr_q & ~retire) | consume;
      int_req   <= grant && !ack_hit;
      vec_valid <= ack_hit;
      if (ack_hit) vec_data <= {base, take ? win_idx : LOWEST_LVL};
    end
  end

  AST_ISR_SET_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|(isr_q & ~$past(isr_q))) |-> $past(ack_hit)); // R7
  AST_SPURIOUS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !grant) |=> (vec_valid && vec_data[LVL_W-1:0] == LOWEST_LVL)); // R9
  AST_SPURIOUS_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !grant) |=> ((isr_q & ~$past(isr_q)) == '0)); // R9
  AST_CASCADE_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && cfg.cas_en && cas_id != cfg.slave_id) |=> !vec_valid); // R10
  AST_NO_PEND_NO_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> !int_req); // R6
  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && svc_any && !ack_hit) |=> ($countones(isr_q) + 1 == $countones($past(isr_q)))); // R8
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       int_ack = 1'b0;
  logic [2:0] cas_id = '0;
  logic       int_req, vec_valid;
  logic [7:0] vec_data;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    run_cmp = 1'b0;
  bit    done = 1'b0;

  always #4 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .int_ack(int_ack), .cas_id(cas_id), .int_req(int_req),
    .vec_valid(vec_valid), .vec_data(vec_data)
  );

  // behavioural reference state
  logic [7:0] m_isr, m_cap, m_prev, m_mask;
  logic       m_level, m_cas;
  logic [2:0] m_id;
  logic [4:0] m_base;
  logic       m_int, m_vv;
  logic [7:0] m_vd;

  always @(posedge clk or negedge rst_n) begin : model
    int p, s;
    logic [7:0] rq, ncap, nisr;
    logic grant, hit, eoi;
    if (!rst_n) begin
      m_isr = 0; m_cap = 0; m_prev = 0; m_mask = 0; m_level = 0; m_cas = 0;
      m_id = 0; m_base = 0; m_int = 0; m_vv = 0; m_vd = 0;
    end else begin
      rq = m_level ? irq_in : m_cap;
      p = 8; s = 8;
      for (int i = 7; i >= 0; i--) begin
        if (rq[i] && !m_mask[i]) p = i;
        if (m_isr[i]) s = i;
      end
      grant = (p < s);
      hit = int_ack && (!m_cas || cas_id == m_id);
      eoi = bus_wr && bus_addr == 2'd3 && bus_wdata[0];
      ncap = (m_cap | (irq_in & ~m_prev)) & irq_in;
      nisr = m_isr;
      if (eoi && s < 8) nisr[s] = 1'b0;
      if (hit && grant) begin ncap[p] = 1'b0; nisr[p] = 1'b1; end
      m_int = grant && !hit;
      m_vv = hit;
      if (hit) m_vd = {m_base, grant ? 3'(p) : 3'd7};
      if (bus_wr) begin
        case (bus_addr)
          2'd0: begin m_level = bus_wdata[0]; m_cas = bus_wdata[1]; m_id = bus_wdata[6:4]; end
          2'd1: m_base = bus_wdata[7:3];
          2'd2: m_mask = bus_wdata;
          default: ;
        endcase
      end
      m_cap = ncap; m_isr = nisr; m_prev = irq_in;
    end
  end

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk("int_req vs model", {7'd0, int_req}, {7'd0, m_int});
      chk("vec_valid vs model", {7'd0, vec_valid}, {7'd0, m_vv});
      if (m_vv) chk("vec_data vs model", vec_data, m_vd);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ack_expect(bit exp_valid, logic [7:0] exp_vec);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    chk("direct vec_valid", {7'd0, vec_valid}, {7'd0, exp_valid});
    if (exp_valid) chk("direct vec_data", vec_data, exp_vec);
    @(negedge clk);
    chk("vec_valid one cycle", {7'd0, vec_valid}, 8'd0);
  endtask

  task automatic int_expect(bit e);
    chk("direct int_req", {7'd0, int_req}, {7'd0, e});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    cur_req = "R1";
    int_expect(0);
    chk("reset vec_valid", {7'd0, vec_valid}, 8'd0);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    tick(2);
    irq_in = 8'h80; tick(3);
    int_expect(1);  // R1: mask clear, nothing in service
    irq_in = 0; tick(2);

    // R2 / R5 / R7 / R8 edge capture and vector
    cur_req = "R5";
    wr_reg(2'd1, 8'h50);
    irq_in = 8'h08; tick(1);
    cur_req = "R2"; int_expect(0); tick(2); int_expect(1);
    cur_req = "R5"; ack_expect(1, 8'h53);
    cur_req = "R7"; int_expect(0);
    cur_req = "R8"; wr_reg(2'd3, 8'h01); tick(3);
    cur_req = "R2"; int_expect(0);  // still high, already consumed
    irq_in = 0; tick(1); irq_in = 8'h08; tick(3); int_expect(1);
    ack_expect(1, 8'h53); wr_reg(2'd3, 8'h01); irq_in = 0; tick(2);

    // R5 / R6 priority and nesting
    cur_req = "R5";
    irq_in = 8'h24; tick(3); int_expect(1);
    ack_expect(1, 8'h52);
    cur_req = "R6"; tick(2); int_expect(0);  // 5 does not outrank 2
    irq_in = 8'h25; tick(3); int_expect(1);  // 0 nests over 2
    ack_expect(1, 8'h50);
    cur_req = "R8"; wr_reg(2'd3, 8'h01); tick(2);
    cur_req = "R6"; int_expect(0);  // 2 still in service
    cur_req = "R8"; wr_reg(2'd3, 8'h01); tick(2); int_expect(1);
    ack_expect(1, 8'h55); wr_reg(2'd3, 8'h01);
    irq_in = 0; tick(2);

    // R4 / R11 mask
    cur_req = "R4";
    wr_reg(2'd2, 8'h10); irq_in = 8'h10; tick(4); int_expect(0);
    cur_req = "R11";
    wr_reg(2'd2, 8'h00); tick(2); int_expect(1);
    ack_expect(1, 8'h54); wr_reg(2'd3, 8'h01); irq_in = 0; tick(2);

    // R3 / R9 level mode and spurious
    cur_req = "R3";
    wr_reg(2'd0, 8'h01); irq_in = 8'h40; tick(2); int_expect(1);
    irq_in = 0; tick(2); int_expect(0);
    cur_req = "R9";
    ack_expect(1, 8'h57);
    irq_in = 8'h80; tick(2); int_expect(1);  // nothing put in service
    irq_in = 0; tick(2);
    cur_req = "R3"; irq_in = 8'h02; tick(2); ack_expect(1, 8'h51);
    irq_in = 0; wr_reg(2'd3, 8'h01); tick(2);

    // R10 cascade matching
    cur_req = "R10";
    wr_reg(2'd0, 8'h52); irq_in = 8'h04; tick(3); int_expect(1);
    cas_id = 3'd3; ack_expect(0, 8'h00);
    int_expect(1);
    cas_id = 3'd5; ack_expect(1, 8'h52);
    wr_reg(2'd3, 8'h01); irq_in = 0; cas_id = 0;
    cur_req = "R11"; wr_reg(2'd0, 8'h00); wr_reg(2'd1, 8'hA8); tick(2);
    irq_in = 8'h01; tick(3); ack_expect(1, 8'hA8); wr_reg(2'd3, 8'h01);
    irq_in = 0; tick(2);

    // random traffic against the model
    cur_req = "R6";
    for (int n = 0; n < 4000; n++) begin
      if ((n % 500) == 0) begin
        bus_wr = 1'b1; bus_addr = 2'd0;
        bus_wdata = {1'b0, 3'($urandom_range(0, 7)), 2'b00, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1))};
      end else if ($urandom_range(0, 40) == 0) begin
        bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'($urandom) & 8'($urandom);
      end else if ($urandom_range(0, 6) == 0) begin
        bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h01;
      end else begin
        bus_wr = 1'b0;
      end
      if ($urandom_range(0, 3) == 0) irq_in = irq_in ^ (8'(1) << $urandom_range(0, 7));
      int_ack = ($urandom_range(0, 5) == 0) && !int_ack;
      cas_id = 3'($urandom_range(0, 7));
      tick(1);
    end
    bus_wr = 1'b0; int_ack = 1'b0; tick(2);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule